// File: doc/BRIEF.md
# Scalable External Bus Wait-State Generator

This block times accesses on an external bus split into eight chip-select areas. Each area supplies its own auto-wait count and its own setup, hold, recovery and idle counts. When an access is requested, the block takes the timing of the selected area, or of the fly-by I/O channel, and steps through setup, auto-wait, hold, a one-cycle completion strobe, recovery and idle. It then returns to its ready state and accepts the next request.

A single 2-bit reduction code scales down the auto-wait count of every area and of the fly-by channel at the same time. It does this by shifting the count right by 0 to 3 bits. This is meant for running on a slow clock: the per-area settings stay as programmed, and setting the code back to zero brings the original timing back. The other phases are never scaled. The effective timing is captured when an access is accepted, so a change of code during an access only applies to the next one.

Top module: `ebus_wait_gen`

## Requirements
- R1: With reduction code 0, the auto-wait phase lasts exactly the programmed 4-bit auto-wait count of the selected source, in clock cycles.
- R2: With reduction code 1, the auto-wait phase lasts the programmed count shifted right by one bit.
- R3: With code 2 the auto-wait phase lasts the count shifted right by two bits, and with code 3 it lasts the count shifted right by three bits. The result truncates toward zero, and a result of 0 removes the auto-wait phase.
- R4: The same reduction applies to all eight areas. When acc_flyby is 1, the auto-wait count comes from flyby_wait instead of the area's field, and the other phases still come from acc_area.
- R5: The setup, hold, recovery and idle phases last exactly the selected area's 2-bit counts, whatever the reduction code.
- R6: The stored settings are never altered, so after any reduced access, setting the code back to 0 gives the full programmed wait again.
- R7: The reduction code and the area timing are captured in the cycle the access is accepted; a code change during an access does not alter that access.
- R8: phase_o reports 0 for ready, 1 for setup, 2 for auto-wait, 3 for hold, 4 for the completion strobe, 5 for recovery and 6 for idle. The phases occur in that increasing order, and a phase with a count of zero is skipped. acc_done is 1 for exactly one cycle per access, namely the strobe cycle, which follows the hold phase.
- R9: busy is 1 in every phase except ready, including recovery and idle. A request made while busy is 1 is ignored, and no access follows from it.
- R10: After reset, phase_o is 0, busy is 0 and acc_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | 32 | Auto-wait count per area, 4 bits each, area 0 in the low bits |
| cfg_setup | input | 16 | Setup count per area, 2 bits each |
| cfg_hold | input | 16 | Hold count per area, 2 bits each |
| cfg_recov | input | 16 | Recovery count per area, 2 bits each |
| cfg_idle | input | 16 | Idle count per area, 2 bits each |
| flyby_wait | input | 4 | Auto-wait count for fly-by I/O accesses |
| reduce_code | input | 2 | Right-shift amount applied to the auto-wait count |
| acc_start | input | 1 | Access request, accepted only while ready |
| acc_area | input | 3 | Chip-select area of the requested access |
| acc_flyby | input | 1 | Requested access is a fly-by I/O cycle |
| phase_o | output | 3 | Current phase code |
| busy | output | 1 | Access or its recovery and idle still in progress |
| acc_done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is a change of the reduction code while an access is running. The change must land after the timing has been captured but before the auto-wait phase is counted. To get there, the stimulus writes code 3 in the first setup cycle of an access whose area has a long wait. The bench expects the full wait for that access and the reduced wait for the following one. A request pulse made in the middle of the auto-wait phase checks that a start while busy is dropped. The main sweep runs every code over all eight areas and the fly-by channel; some of their counts are zero, so the skip path is exercised from every phase.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

   typedef enum logic [2:0] {
      PH_READY = 3'd0,
      PH_SETUP = 3'd1,
      PH_WAIT  = 3'd2,
      PH_HOLD  = 3'd3,
      PH_DONE  = 3'd4,
      PH_RECOV = 3'd5,
      PH_IDLE  = 3'd6
   } phase_e;

   localparam int NUM_SLOT = 8;
   localparam int LAST_PH  = 6;

   // first phase after cur whose length is nonzero, or ready
   function automatic phase_e next_phase(input phase_e cur, input logic [NUM_SLOT-1:0] live);
      phase_e res;
      res = PH_READY;
      for (int p = LAST_PH; p >= 1; p--) begin
         if ((p > int'(cur)) && live[p]) res = phase_e'(p[2:0]);
      end
      return res;
   endfunction

endpackage

// File: rtl/ebw_area_select.sv
module ebw_area_select #(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 4,
   parameter int PHASE_W   = 2,
   localparam int AREA_W   = $clog2(NUM_AREAS)
) (
   input  logic [NUM_AREAS*WAIT_W-1:0]  cfg_wait,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_setup,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_hold,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_recov,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_idle,
   input  logic [WAIT_W-1:0]            flyby_wait,
   input  logic [AREA_W-1:0]            area,
   input  logic                         flyby,
   output logic [WAIT_W-1:0]            sel_wait,
   output logic [PHASE_W-1:0]           sel_setup,
   output logic [PHASE_W-1:0]           sel_hold,
   output logic [PHASE_W-1:0]           sel_recov,
   output logic [PHASE_W-1:0]           sel_idle
);

   if (NUM_AREAS < 2 || (1 << AREA_W) != NUM_AREAS) begin : g_bad_areas
      $error("NUM_AREAS must be a power of two of at least 2");
   end

   logic [WAIT_W-1:0]  w_arr [NUM_AREAS];
   logic [PHASE_W-1:0] s_arr [NUM_AREAS];
   logic [PHASE_W-1:0] h_arr [NUM_AREAS];
   logic [PHASE_W-1:0] r_arr [NUM_AREAS];
   logic [PHASE_W-1:0] i_arr [NUM_AREAS];

   for (genvar a = 0; a < NUM_AREAS; a++) begin : g_unpack
      assign w_arr[a] = cfg_wait[a*WAIT_W +: WAIT_W];
      assign s_arr[a] = cfg_setup[a*PHASE_W +: PHASE_W];
      assign h_arr[a] = cfg_hold[a*PHASE_W +: PHASE_W];
      assign r_arr[a] = cfg_recov[a*PHASE_W +: PHASE_W];
      assign i_arr[a] = cfg_idle[a*PHASE_W +: PHASE_W];
   end

   assign sel_wait  = flyby ? flyby_wait : w_arr[area];
   assign sel_setup = s_arr[area];
   assign sel_hold  = h_arr[area];
   assign sel_recov = r_arr[area];
   assign sel_idle  = i_arr[area];

endmodule

// File: rtl/ebw_reduce.sv
module ebw_reduce #(
   parameter int WAIT_W    = 4,
   parameter int CODE_W    = 2,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [WAIT_W-1:0] raw_wait,
   input  logic [CODE_W-1:0] code,
   output logic [WAIT_W-1:0] eff_wait
);

   localparam int NUM_CODES = 1 << CODE_W;

   if (WAIT_W < 2) begin : g_bad_width
      $error("WAIT_W must be at least 2");
   end

   if (USE_TABLE) begin : g_table
      logic [WAIT_W-1:0] cand [NUM_CODES];
      for (genvar c = 0; c < NUM_CODES; c++) begin : g_cand
         assign cand[c] = raw_wait >> c;
      end
      assign eff_wait = cand[code];
   end else begin : g_shift
      assign eff_wait = raw_wait >> code;
   end

   always_comb begin
      AST_EFF_NOT_ABOVE: assert (eff_wait <= raw_wait); // R2
   end

endmodule

// File: rtl/ebw_sequencer.sv
module ebw_sequencer
   import ebw_pkg::*;
#(
   parameter int WAIT_W  = 4,
   parameter int PHASE_W = 2,
   localparam int LEN_W  = (WAIT_W > PHASE_W) ? WAIT_W : PHASE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PHASE_W-1:0] in_setup,
   input  logic [WAIT_W-1:0]  in_wait,
   input  logic [PHASE_W-1:0] in_hold,
   input  logic [PHASE_W-1:0] in_recov,
   input  logic [PHASE_W-1:0] in_idle,
   output phase_e             phase,
   output logic               done,
   output logic               busy
);

   logic [LEN_W-1:0]    len_in [NUM_SLOT];
   logic [LEN_W-1:0]    len_q  [NUM_SLOT];
   logic [NUM_SLOT-1:0] live_in, live_q;
   phase_e              phase_q, phase_d;
   logic [LEN_W-1:0]    cnt_q, cnt_d;
   logic                accept, load;

   assign len_in[PH_READY] = '0;
   assign len_in[PH_SETUP] = LEN_W'(in_setup);
   assign len_in[PH_WAIT]  = LEN_W'(in_wait);
   assign len_in[PH_HOLD]  = LEN_W'(in_hold);
   assign len_in[PH_DONE]  = LEN_W'(1);
   assign len_in[PH_RECOV] = LEN_W'(in_recov);
   assign len_in[PH_IDLE]  = LEN_W'(in_idle);
   assign len_in[7]        = '0;

   for (genvar p = 0; p < NUM_SLOT; p++) begin : g_live
      assign live_in[p] = |len_in[p];
      assign live_q[p]  = |len_q[p];
   end

   always_comb begin
      accept  = start && (phase_q == PH_READY);
      phase_d = phase_q;
      load    = 1'b0;
      if (accept) begin
         phase_d = next_phase(PH_READY, live_in);
         load    = 1'b1;
      end else if (phase_q != PH_READY && cnt_q == '0) begin
         phase_d = next_phase(phase_q, live_q);
         load    = 1'b1;
      end
      if (load) begin
         if (phase_d == PH_READY) cnt_d = '0;
         else if (accept)         cnt_d = len_in[phase_d] - LEN_W'(1);
         else                     cnt_d = len_q[phase_d] - LEN_W'(1);
      end else if (phase_q != PH_READY) begin
         cnt_d = cnt_q - LEN_W'(1);
      end else begin
         cnt_d = cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_READY;
         cnt_q   <= '0;
         for (int p = 0; p < NUM_SLOT; p++) len_q[p] <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         if (accept) begin
            for (int p = 0; p < NUM_SLOT; p++) len_q[p] <= len_in[p];
         end
      end
   end

   assign phase = phase_q;
   assign done  = (phase_q == PH_DONE);
   assign busy  = (phase_q != PH_READY);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_THEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (phase_q inside {PH_RECOV, PH_IDLE, PH_READY})); // R8

   AST_TIMING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(len_q[PH_WAIT])); // R7

   AST_TAIL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q inside {PH_RECOV, PH_IDLE}) |=> (phase_q inside {PH_RECOV, PH_IDLE, PH_READY})); // R9

   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_READY && !start) |=> (phase_q == PH_READY)); // R9

endmodule

// File: rtl/ebus_wait_gen.sv
module ebus_wait_gen
   import ebw_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 4,
   parameter int PHASE_W   = 2,
   parameter int CODE_W    = 2,
   parameter bit USE_TABLE = 1'b1,
   localparam int AREA_W   = $clog2(NUM_AREAS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_AREAS*WAIT_W-1:0]  cfg_wait,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_setup,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_hold,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_recov,
   input  logic [NUM_AREAS*PHASE_W-1:0] cfg_idle,
   input  logic [WAIT_W-1:0]            flyby_wait,
   input  logic [CODE_W-1:0]            reduce_code,
   input  logic                         acc_start,
   input  logic [AREA_W-1:0]            acc_area,
   input  logic                         acc_flyby,
   output logic [2:0]                   phase_o,
   output logic                         busy,
   output logic                         acc_done
);

   logic [WAIT_W-1:0]  raw_wait, eff_wait;
   logic [PHASE_W-1:0] s_len, h_len, r_len, i_len;
   phase_e             phase;

   ebw_area_select #(
      .NUM_AREAS (NUM_AREAS),
      .WAIT_W    (WAIT_W),
      .PHASE_W   (PHASE_W)
   ) u_sel (
      .cfg_wait   (cfg_wait),
      .cfg_setup  (cfg_setup),
      .cfg_hold   (cfg_hold),
      .cfg_recov  (cfg_recov),
      .cfg_idle   (cfg_idle),
      .flyby_wait (flyby_wait),
      .area       (acc_area),
      .flyby      (acc_flyby),
      .sel_wait   (raw_wait),
      .sel_setup  (s_len),
      .sel_hold   (h_len),
      .sel_recov  (r_len),
      .sel_idle   (i_len)
   );

   ebw_reduce #(
      .WAIT_W    (WAIT_W),
      .CODE_W    (CODE_W),
      .USE_TABLE (USE_TABLE)
   ) u_red (
      .raw_wait (raw_wait),
      .code     (reduce_code),
      .eff_wait (eff_wait)
   );

   ebw_sequencer #(
      .WAIT_W  (WAIT_W),
      .PHASE_W (PHASE_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc_start),
      .in_setup (s_len),
      .in_wait  (eff_wait),
      .in_hold  (h_len),
      .in_recov (r_len),
      .in_idle  (i_len),
      .phase    (phase),
      .done     (acc_done),
      .busy     (busy)
   );

   assign phase_o = phase;

   AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> busy); // R8

   AST_START_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !acc_start) |=> !busy); // R9

endmodule

// File: tb/ebus_wait_gen_bench.sv
module ebus_wait_gen_bench;

   localparam int PERIOD = 10;
   localparam int NA = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NA*4-1:0] cfg_wait;
   logic [NA*2-1:0] cfg_setup, cfg_hold, cfg_recov, cfg_idle;
   logic [3:0]      flyby_wait = 4'd12;
   logic [1:0]      reduce_code = 2'd0;
   logic            acc_start = 1'b0;
   logic [2:0]      acc_area = 3'd0;
   logic            acc_flyby = 1'b0;
   logic [2:0]      phase_o;
   logic            busy, acc_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ebus_wait_gen u_ebus_wait_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_setup(cfg_setup),
      .cfg_hold(cfg_hold), .cfg_recov(cfg_recov), .cfg_idle(cfg_idle),
      .flyby_wait(flyby_wait), .reduce_code(reduce_code), .acc_start(acc_start),
      .acc_area(acc_area), .acc_flyby(acc_flyby), .phase_o(phase_o),
      .busy(busy), .acc_done(acc_done)
   );

   function automatic int w_of(input int a);  return 15 - 2*a;      endfunction
   function automatic int s_of(input int a);  return a % 4;         endfunction
   function automatic int h_of(input int a);  return (a >> 1) % 4;  endfunction
   function automatic int r_of(input int a);  return (a + 2) % 4;   endfunction
   function automatic int i_of(input int a);  return (a * 3) % 4;   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Runs one access; mid_code >= 0 changes the code in the first busy cycle,
   // poke pulses acc_start in the third busy cycle.
   task automatic run_access(input int area, input bit fly, input string wtag,
                             input int mid_code, input bit poke);
      int cnt [8];
      int code0, exp_w, prev, order_bad, done_bad, busy_bad, n;
      for (int p = 0; p < 8; p++) cnt[p] = 0;
      code0 = int'(reduce_code);
      exp_w = (fly ? int'(flyby_wait) : w_of(area)) >> code0;
      @(negedge clk);
      acc_area  = 3'(area);
      acc_flyby = fly;
      acc_start = 1'b1;
      @(negedge clk);
      acc_start = 1'b0;
      prev = 0; order_bad = 0; done_bad = 0; busy_bad = 0; n = 0;
      while (phase_o != 3'd0 && n < 200) begin
         cnt[phase_o]++;
         if (int'(phase_o) < prev) order_bad++;
         if (acc_done != (phase_o == 3'd4)) done_bad++;
         if (!busy) busy_bad++;
         prev = int'(phase_o);
         if (n == 0 && mid_code >= 0) reduce_code = 2'(mid_code);
         if (poke) acc_start = (n == 2);
         n++;
         @(negedge clk);
      end
      acc_start = 1'b0;
      check(wtag, cnt[2], exp_w, $sformatf("wait cycles area %0d fly %0d code %0d", area, fly, code0));
      check("R5", cnt[1], s_of(area), $sformatf("setup cycles area %0d", area));
      check("R5", cnt[3], h_of(area), $sformatf("hold cycles area %0d", area));
      check("R5", cnt[5], r_of(area), $sformatf("recovery cycles area %0d", area));
      check("R5", cnt[6], i_of(area), $sformatf("idle cycles area %0d", area));
      check("R8", order_bad, 0, "phase order violations");
      check("R8", cnt[4], 1, "done strobe cycles");
      check("R8", done_bad, 0, "done outside strobe phase");
      check("R9", busy_bad, 0, "busy low during access");
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      string tg;
      for (int a = 0; a < NA; a++) begin
         cfg_wait[a*4 +: 4]  = 4'(w_of(a));
         cfg_setup[a*2 +: 2] = 2'(s_of(a));
         cfg_hold[a*2 +: 2]  = 2'(h_of(a));
         cfg_recov[a*2 +: 2] = 2'(r_of(a));
         cfg_idle[a*2 +: 2]  = 2'(i_of(a));
      end
      acc_start = 1'b1;
      repeat (3) @(negedge clk);
      check("R10", int'(phase_o), 0, "phase in reset");
      check("R10", int'(busy), 0, "busy in reset");
      check("R10", int'(acc_done), 0, "done in reset");
      acc_start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", int'(busy), 0, "busy after reset release");

      // sweep all codes over all areas and the fly-by channel
      for (int c = 0; c < 4; c++) begin
         reduce_code = 2'(c);
         tg = (c == 0) ? "R1" : (c == 1) ? "R2" : "R3";
         for (int a = 0; a < NA; a++) run_access(a, 1'b0, tg, -1, 1'b0);
         run_access(5, 1'b1, "R4", -1, 1'b0);
      end

      // code back to zero restores programmed waits
      reduce_code = 2'd0;
      run_access(0, 1'b0, "R6", -1, 1'b0);
      run_access(6, 1'b0, "R6", -1, 1'b0);

      // mid-access code change applies only to the next access
      reduce_code = 2'd0;
      run_access(3, 1'b0, "R7", 3, 1'b0);
      run_access(3, 1'b0, "R7", -1, 1'b0);

      // request while busy is ignored
      reduce_code = 2'd0;
      run_access(1, 1'b0, "R1", -1, 1'b1);
      for (int k = 0; k < 3; k++) begin
         check("R9", int'(phase_o), 0, "phase after ignored request");
         check("R9", int'(busy), 0, "busy after ignored request");
         @(negedge clk);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule